// File: doc/BRIEF.md
# Three-Channel Constant-Weight Hierarchical Encoder

This block turns each 6-bit data word into three 4-wire codewords. Every codeword has exactly two wires high, so each channel keeps constant weight. The code has two levels. In the upper level, the top three data bits form a value from 0 to 7. That value is written as two base-3 digits, and a third base-3 digit is added as their modulo-3 sum. Each of these three digits picks one of three codeword subsets, one subset per channel. In the lower level, each of the three remaining data bits picks one of the two members of its channel's subset. Twelve wires carry six data bits, a code rate of one half. A receiver can use the subset checksum to locate and repair a single-wire error in one channel.

The input side is a valid/ready stream. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. The encoded result appears one cycle later in an output register, flagged by `out_valid`. That register is held while the consumer keeps `out_ready` low. Back-pressure passes straight through: `in_ready` is high whenever the register is empty or is being drained in the same cycle. As a result, a consumer that never stalls sees one word per clock.

Top module: `tri_channel_wcode_enc`

## Requirements
- R1: Every 4-bit channel word presented with `out_valid` high has exactly two bits set.
- R2: Subset index 0 holds {0011, 1100}, index 1 holds {0101, 1010}, and index 2 holds {0110, 1001}. A member select of 0 sends the first-listed word (ones in the low positions), and a select of 1 sends its bitwise complement.
- R3: With v = `in_data[5:3]` read as unsigned binary, channel 2 (`out_code[11:8]`) uses subset v/3 and channel 1 (`out_code[7:4]`) uses subset v mod 3.
- R4: Channel 0 (`out_code[3:0]`) uses subset (v/3 + v mod 3) mod 3.
- R5: `in_data[2]` selects the member on channel 2, `in_data[1]` on channel 1 and `in_data[0]` on channel 0. For example, input 111101 gives `out_code` 1001_0101_1100.
- R6: A word accepted on a clock edge appears on `out_code` with `out_valid` high right after that edge, one cycle of latency.
- R7: `in_ready` equals `!out_valid || out_ready`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_code` stay unchanged on the next edge.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.
- R10: If the register is drained and a new word is accepted on the same edge, the new word replaces the old one with no empty cycle.
- R11: Channels 2 and 1 never both carry subset-2 words, because the digit pair 2,2 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Encoder can take a word this cycle |
| in_data | input | 6 | [5:3] checksum value, [2:0] member selects |
| out_valid | output | 1 | `out_code` holds an encoded word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_code | output | 12 | Channel 2 at [11:8], channel 1 at [7:4], channel 0 at [3:0] |

## Verification
Two of this block's functions can fall on the same edge: draining the output register and loading a new encoded word into it. The bench causes this by holding `in_valid` and `out_ready` high through a sweep of all 64 inputs. It expects a fresh code on every cycle with no gap and no repeat. Random stall patterns on `out_ready` then mix holds, drains and refills. A behavioural queue model predicts `in_ready`, `out_valid` and `out_code` on each clock, and the bench compares the design against it.

// File: rtl/wcode_pkg.sv
package wcode_pkg;
  localparam int WIRES     = 4;
  localparam int CHANNELS  = 3;
  localparam int SUBSETS   = 3;
  localparam int TRIT_W    = $clog2(SUBSETS);
  localparam int SEL_BITS  = CHANNELS;
  localparam int VAL_BITS  = 3;
  localparam int DATA_W    = VAL_BITS + SEL_BITS;
  localparam int CODE_W    = WIRES * CHANNELS;

  typedef logic [TRIT_W-1:0] trit_t;
  typedef logic [WIRES-1:0]  cw_t;
endpackage

// File: rtl/wcode_digit_split.sv
module wcode_digit_split
  import wcode_pkg::*;
(
  input  logic [VAL_BITS-1:0] value,
  output trit_t               dig_hi,
  output trit_t               dig_lo,
  output trit_t               dig_chk
);
  logic [TRIT_W:0] sum;

  always_comb begin
    dig_hi = TRIT_W'(value / VAL_BITS'(SUBSETS));
    dig_lo = TRIT_W'(value % VAL_BITS'(SUBSETS));
    sum    = {1'b0, dig_hi} + {1'b0, dig_lo};
    if (sum >= (TRIT_W+1)'(SUBSETS)) dig_chk = TRIT_W'(sum - (TRIT_W+1)'(SUBSETS));
    else                             dig_chk = TRIT_W'(sum);
  end

  // R3: the two digits rebuild the binary value
  always_comb begin
    p_digits_r3: assert (int'(dig_hi) * SUBSETS + int'(dig_lo) == int'(value));
  end
endmodule

// File: rtl/wcode_subset_pick.sv
module wcode_subset_pick
  import wcode_pkg::*;
(
  input  trit_t subset,
  input  logic  member,
  output cw_t   word
);
  cw_t base;

  always_comb begin
    unique case (subset)
      TRIT_W'(0): base = 4'b0011;
      TRIT_W'(1): base = 4'b0101;
      TRIT_W'(2): base = 4'b0110;
      default:    base = 4'b0011;
    endcase
    word = member ? ~base : base;
  end

  // R1: each picked word is weight two
  always_comb begin
    p_weight_r1: assert ($countones(word) == 2);
  end
endmodule

// File: rtl/tri_channel_wcode_enc.sv
module tri_channel_wcode_enc
  import wcode_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [CODE_W-1:0]  out_code
);
  trit_t  subs [CHANNELS];
  logic [CODE_W-1:0] code_next;

  wcode_digit_split u_split (
    .value   (in_data[DATA_W-1 -: VAL_BITS]),
    .dig_hi  (subs[2]),
    .dig_lo  (subs[1]),
    .dig_chk (subs[0])
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    wcode_subset_pick u_pick (
      .subset (subs[ch]),
      .member (in_data[ch]),
      .word   (code_next[ch*WIRES +: WIRES])
    );
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_code  <= code_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_accept_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_code));
  p_stall_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);
  p_weight_out_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_code[11:8]) == 2 && $countones(out_code[7:4]) == 2
                   && $countones(out_code[3:0]) == 2));
  p_no_pair22_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !((out_code[11:8] == 4'b0110 || out_code[11:8] == 4'b1001) &&
                    (out_code[7:4] == 4'b0110 || out_code[7:4] == 4'b1001)));
endmodule

// File: tb/tri_channel_wcode_enc_test.sv
module tri_channel_wcode_enc_test;
  logic clk = 0;
  logic rst = 1;
  logic in_valid = 0;
  logic out_ready = 0;
  logic [5:0] in_data = 0;
  logic in_ready, out_valid;
  logic [11:0] out_code;
  int total = 0, bad = 0, cycles = 0;
  logic ev = 0;
  logic [11:0] ec = 0;
  logic [11:0] prev_code = 0;
  logic prev_valid = 0;

  always #10 clk = ~clk;

  tri_channel_wcode_enc uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code));

  function automatic logic [3:0] member(int sub, bit sel);
    logic [3:0] w;
    w = (sub == 0) ? 4'b0011 : (sub == 1) ? 4'b0101 : 4'b0110;
    return sel ? ~w : w;
  endfunction

  function automatic logic [11:0] enc(logic [5:0] d);
    int v, hi, lo, pc;
    v = int'(d[5:3]); hi = v / 3; lo = v % 3; pc = (hi + lo) % 3;
    return {member(hi, d[2]), member(lo, d[1]), member(pc, d[0])};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (rst) ev <= 0;
    else if (in_valid && (!ev || out_ready)) begin ev <= 1; ec <= enc(in_data); end
    else if (out_ready) ev <= 0;
  end

  // compare every cycle away from the edge
  always @(negedge clk) begin
    cycles++;
    check(in_ready == (!ev || out_ready), "R7 in_ready", 32'(in_ready), 32'(!ev || out_ready));
    check(out_valid == ev, "R6 out_valid", 32'(out_valid), 32'(ev));
    if (ev) begin
      check(out_code == ec, "R2 R3 R4 R5 out_code", 32'(out_code), 32'(ec));
      check($countones(out_code[11:8]) == 2 && $countones(out_code[7:4]) == 2 &&
            $countones(out_code[3:0]) == 2, "R1 weight", 32'(out_code), 32'(ec));
      check(!((out_code[11:8] == 4'b0110 || out_code[11:8] == 4'b1001) &&
              (out_code[7:4] == 4'b0110 || out_code[7:4] == 4'b1001)), "R11 pair", 32'(out_code), 32'(ec));
      if (prev_valid && !out_ready && !rst)
        check(out_code == prev_code, "R8 hold", 32'(out_code), 32'(prev_code));
    end
    prev_valid = out_valid && !out_ready;
    prev_code  = out_code;
    if (cycles > 20000) begin
      check(0, "watchdog", 32'(cycles), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && in_ready, "R9 reset", {30'b0, out_valid, in_ready}, 32'b01);
    @(negedge clk); #2 rst = 0;
    @(negedge clk); #1;
    check(!out_valid && in_ready, "R9 after reset", {30'b0, out_valid, in_ready}, 32'b01);
    // R5 worked example
    #1 in_valid = 1; in_data = 6'b111101; out_ready = 1;
    @(posedge clk); #5;
    check(out_code == 12'b1001_0101_1100, "R5 example", 32'(out_code), 32'h95C);
    // R10 sweep with full throughput
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); #2 in_data = 6'(i);
      @(posedge clk); #5;
      check(out_valid && out_code == enc(6'(i)), "R10 streaming", 32'(out_code), 32'(enc(6'(i))));
    end
    // back-pressure mixes
    for (int k = 0; k < 400; k++) begin
      @(negedge clk); #2;
      in_valid  = ((k * 7 + 3) % 5) != 0;
      out_ready = ((k * 11 + 1) % 3) != 0;
      in_data   = 6'((k * 37 + 5) % 64);
    end
    @(negedge clk); #2 in_valid = 0; out_ready = 1;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule